// File: doc/BRIEF.md
# Partitioned Multi-Operand Add Reducer

The block adds a fixed, elaboration-time number of 16-bit operands, anywhere from none to fifteen, into a single 16-bit word. Two run-time enables split the word at bit 4 and at bit 8. When a split is enabled, no carry crosses it. Each resulting lane therefore holds the sum of every operand's bits in that lane, wrapped to the lane's own width. A SIMD datapath uses it to accumulate several packed values per cycle, either as one wide lane or as narrower ones.

Internally the operands pass through a tree of 3:2 carry-save levels. Each level shifts its carry word up by one position and drops any carry that would enter an enabled split. When at most two words remain, a partitioned two-input adder merges them. A bit-mask parameter chooses which levels are followed by a pipeline register. Level 0 is the operand input, and level k is the output of the k-th carry-save level. The split enables move through the same registers as the data, so every result is formed with the split setting that was present when its operands were applied. A mask that selects a level deeper than the tree, or an operand count above fifteen, stops elaboration with an error.

Top module: `part_add_reduce`

## Requirements
- R1: With an operand count of zero, `sum` is 0 whatever is driven on `ops`.
- R2: With both enables low, `sum` equals the sum of all operands modulo 2^16.
- R3: With only `split_hi_en` (bit 8) high, `sum[15:8]` and `sum[7:0]` are each the sum of the operands' corresponding byte, truncated to 8 bits.
- R4: With only `split_lo_en` (bit 4) high, `sum[15:4]` is the 12-bit truncated sum of the operands' bits 15:4 and `sum[3:0]` is the 4-bit truncated sum of their bits 3:0.
- R5: With both enables high, `sum[15:8]`, `sum[7:4]` and `sum[3:0]` are three independent truncated lane sums.
- R6: Bit k of `REG_MASK` places a register after level k (level 0 = the operand inputs, level k ≥ 1 = after the k-th 3:2 level). The result for operands applied before a clock edge appears after exactly popcount(`REG_MASK`) edges, one result per cycle.
- R7: Each result uses the split enables that were applied together with its operands, even when the enables change every cycle.
- R8: While `rst_n` is low, and after it rises until the first operands reach the output, `sum` is 0. This holds when at least one register level is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline registers |
| ops | input | max(N_OPS,1)*16 | Operand i in bits [16*i+15:16*i] |
| split_lo_en | input | 1 | Block carries into bit 4 |
| split_hi_en | input | 1 | Block carries into bit 8 |
| sum | output | 16 | Lane-wise reduced sum |

## Verification
Every cycle, each carry-save level is checked to keep every lane's total of its terms unchanged under the present split setting. The final adder is checked against whole-lane additions for each of the four settings, and against the rule that nothing beyond its two terms is non-zero. Only the bench scenarios can show the end-to-end timing: the latency set by the register mask, the pairing of split setting with operands across the pipeline, the zero output in reset, and the empty configuration. The bench covers these with all-zero, all-ones, 0x0111 and pseudo-random operands under each setting, and with the setting changed on every cycle.

// File: rtl/par_pkg.sv
// Package par_pkg
// Shared types and elaboration-time helpers for the partitioned add reducer.
// Assumes operand counts small enough that the loops below end quickly.
package par_pkg;

    // Split enables carried down the pipeline with the data.
    typedef struct packed {
        logic lo;   // block carry into the lower split point
        logic hi;   // block carry into the upper split point
    } split_t;

    // Terms left after one 3:2 level acting on n terms.
    function automatic int after_level(input int n);
        if (n <= 2) return n;
        return 2 * (n / 3) + (n % 3);
    endfunction

    // Number of 3:2 levels needed to bring n terms down to two or fewer.
    function automatic int tree_depth(input int n);
        int t;
        int d;
        t = n;
        d = 0;
        while (t > 2) begin
            t = after_level(t);
            d = d + 1;
        end
        return d;
    endfunction

    // Terms present at the output of level k (level 0 = inputs).
    function automatic int terms_at(input int n, input int k);
        int t;
        t = n;
        for (int i = 0; i < k; i++) t = after_level(t);
        return t;
    endfunction

endpackage

// File: rtl/par_stage_reg.sv
// Module par_stage_reg
// Optional pipeline register for one tree level. When USE_REG is 1 the
// word is captured each rising edge and cleared by the synchronous
// active-low reset; when 0 the word passes straight through.
module par_stage_reg #(
    parameter int DW      = 34,
    parameter bit USE_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    generate
        if (USE_REG) begin : g_reg
            logic [DW-1:0] q_r;
            // Capture the level output, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_wire
            logic unused_clk;
            // Pass-through: the level is not registered.
            assign unused_clk = clk ^ rst_n;
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/par_csa_level.sv
// Module par_csa_level
// One 3:2 carry-save level. Terms are taken three at a time; each group
// yields a sum word and a carry word shifted up by one, with the carry
// into any enabled split point dropped. One or two left-over terms pass
// unchanged. Slots at and above OUT_T are driven to zero.
// Assumes IN_T > 2 and IN_T <= MAXT.
module par_csa_level
    import par_pkg::*;
#(
    parameter int W     = 16,
    parameter int LO    = 4,
    parameter int HI    = 8,
    parameter int MAXT  = 9,
    parameter int IN_T  = 9,
    localparam int GROUPS = IN_T / 3,
    localparam int REST   = IN_T % 3,
    localparam int OUT_T  = 2 * GROUPS + REST,
    localparam int TW     = MAXT * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  split_t        split,
    input  logic [TW-1:0] in_terms,
    output logic [TW-1:0] out_terms
);

    logic [W-1:0] keep;

    // Carry keep mask: clear the bit a carry would enter at a live split.
    always_comb begin
        keep = '1;
        if (split.lo) keep[LO] = 1'b0;
        if (split.hi) keep[HI] = 1'b0;
    end

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            logic [W-1:0] x, y, z, maj;
            assign x   = in_terms[(3*g)*W   +: W];
            assign y   = in_terms[(3*g+1)*W +: W];
            assign z   = in_terms[(3*g+2)*W +: W];
            assign maj = (x & y) | (x & z) | (y & z);
            assign out_terms[(2*g)*W   +: W] = x ^ y ^ z;
            assign out_terms[(2*g+1)*W +: W] = {maj[W-2:0], 1'b0} & keep;
        end
        for (genvar r = 0; r < REST; r++) begin : g_rest
            assign out_terms[(2*GROUPS+r)*W +: W] = in_terms[(3*GROUPS+r)*W +: W];
        end
        for (genvar j = OUT_T; j < MAXT; j++) begin : g_zero
            assign out_terms[j*W +: W] = '0;
        end
    endgenerate

    localparam logic [W-1:0] M_FULL = '1;
    localparam logic [W-1:0] M_HI8  = M_FULL << HI;
    localparam logic [W-1:0] M_LO8  = ~M_HI8;
    localparam logic [W-1:0] M_HI12 = M_FULL << LO;
    localparam logic [W-1:0] M_N0   = ~M_HI12;
    localparam logic [W-1:0] M_N1   = M_HI12 & M_LO8;

    // Lane total of all terms in a vector, wrapped to the lane.
    function automatic logic [W-1:0] lane_total(input logic [TW-1:0] v,
                                                 input logic [W-1:0] m);
        logic [W-1:0] acc;
        acc = '0;
        for (int s = 0; s < MAXT; s++) acc = acc + (v[s*W +: W] & m);
        return acc & m;
    endfunction

    AST_CSA_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!split.lo && !split.hi) |->
        lane_total(in_terms, M_FULL) == lane_total(out_terms, M_FULL)); // R2
    AST_CSA_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (!split.lo && split.hi) |->
        (lane_total(in_terms, M_HI8) == lane_total(out_terms, M_HI8) &&
         lane_total(in_terms, M_LO8) == lane_total(out_terms, M_LO8))); // R3
    AST_CSA_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (split.lo && !split.hi) |->
        (lane_total(in_terms, M_HI12) == lane_total(out_terms, M_HI12) &&
         lane_total(in_terms, M_N0) == lane_total(out_terms, M_N0))); // R4
    AST_CSA_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (split.lo && split.hi) |->
        (lane_total(in_terms, M_HI8) == lane_total(out_terms, M_HI8) &&
         lane_total(in_terms, M_N1) == lane_total(out_terms, M_N1) &&
         lane_total(in_terms, M_N0) == lane_total(out_terms, M_N0))); // R5

endmodule

// File: rtl/par_final_add.sv
// Module par_final_add
// Partitioned two-input adder closing the tree. Adds slots 0 and 1 in
// three segments; the carry between segments is blocked when the split
// at that boundary is enabled. Assumes slots 2 and above carry zero.
module par_final_add
    import par_pkg::*;
#(
    parameter int W    = 16,
    parameter int LO   = 4,
    parameter int HI   = 8,
    parameter int MAXT = 9,
    localparam int TW  = MAXT * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  split_t        split,
    input  logic [TW-1:0] terms,
    output logic [W-1:0]  sum
);

    logic [W-1:0]    a, b;
    logic [LO:0]     s0;
    logic [HI-LO:0]  s1;
    logic [W-HI-1:0] s2;
    logic            c0, c1;

    assign a = terms[0 +: W];
    assign b = terms[W +: W];

    // Segment adds with carries gated at live split points.
    always_comb begin
        s0 = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]};
        c0 = s0[LO] & ~split.lo;
        s1 = {1'b0, a[HI-1:LO]} + {1'b0, b[HI-1:LO]} + {{(HI-LO){1'b0}}, c0};
        c1 = s1[HI-LO] & ~split.hi;
        s2 = a[W-1:HI] + b[W-1:HI] + {{(W-HI-1){1'b0}}, c1};
        sum = {s2, s1[HI-LO-1:0], s0[LO-1:0]};
    end

    logic tail_zero;
    // Any term beyond the two added ones must be zero.
    always_comb begin
        tail_zero = 1'b1;
        for (int s = 2; s < MAXT; s++)
            if (terms[s*W +: W] != '0) tail_zero = 1'b0;
    end

    AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tail_zero); // R2
    AST_ADD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!split.lo && !split.hi) |-> sum == W'(a + b)); // R2
    AST_ADD_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (!split.lo && split.hi) |->
        (sum[W-1:HI] == (W-HI)'(a[W-1:HI] + b[W-1:HI]) &&
         sum[HI-1:0] == HI'(a[HI-1:0] + b[HI-1:0]))); // R3
    AST_ADD_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (split.lo && !split.hi) |->
        (sum[W-1:LO] == (W-LO)'(a[W-1:LO] + b[W-1:LO]) &&
         sum[LO-1:0] == LO'(a[LO-1:0] + b[LO-1:0]))); // R4
    AST_ADD_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (split.lo && split.hi) |->
        (sum[W-1:HI] == (W-HI)'(a[W-1:HI] + b[W-1:HI]) &&
         sum[HI-1:LO] == (HI-LO)'(a[HI-1:LO] + b[HI-1:LO]) &&
         sum[LO-1:0] == LO'(a[LO-1:0] + b[LO-1:0]))); // R5

endmodule

// File: rtl/part_add_reduce.sv
// Module part_add_reduce
// Top of the partitioned multi-operand add reducer. Builds a chain of
// 3:2 levels sized from N_OPS, an optional register after each level as
// chosen by REG_MASK (bit 0 = inputs), and a partitioned final adder.
// The split enables travel with the data through every register.
// Assumes N_OPS <= 15 and REG_MASK selects no level deeper than the tree.
module part_add_reduce
    import par_pkg::*;
#(
    parameter int          N_OPS    = 9,
    parameter int          W        = 16,
    parameter int          LO       = 4,
    parameter int          HI       = 8,
    parameter logic [15:0] REG_MASK = 16'h0015,
    localparam int DEPTH = tree_depth(N_OPS),
    localparam int MAXT  = (N_OPS < 2) ? 2 : N_OPS,
    localparam int TW    = MAXT * W,
    localparam int DW    = TW + 2,
    localparam int OPS_W = ((N_OPS > 0) ? N_OPS : 1) * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPS_W-1:0] ops,
    input  logic             split_lo_en,
    input  logic             split_hi_en,
    output logic [W-1:0]     sum
);

    localparam logic [15:0] ALLOWED = (16'h1 << (DEPTH + 1)) - 16'h1;

    generate
        if (N_OPS > 15 || N_OPS < 0 || (REG_MASK & ~ALLOWED) != 16'h0) begin : g_bad_cfg
            $error("part_add_reduce: operand count or register level out of range");
        end
    endgenerate

    logic [DW-1:0] raw [0:DEPTH];
    logic [DW-1:0] lvl [0:DEPTH];
    logic [TW-1:0] in_terms;

    // Spread the operands over the term slots, zero-filling the rest.
    generate
        for (genvar s = 0; s < MAXT; s++) begin : g_in
            if (s < N_OPS) begin : g_op
                assign in_terms[s*W +: W] = ops[s*W +: W];
            end else begin : g_pad
                assign in_terms[s*W +: W] = '0;
            end
        end
        if (N_OPS == 0) begin : g_no_ops
            logic unused_ops;
            assign unused_ops = ^ops;
        end
    endgenerate

    assign raw[0] = {split_lo_en, split_hi_en, in_terms};

    generate
        for (genvar k = 0; k <= DEPTH; k++) begin : g_lvl
            par_stage_reg #(
                .DW      (DW),
                .USE_REG (REG_MASK[k])
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw[k]),
                .q     (lvl[k])
            );
        end
        for (genvar k = 1; k <= DEPTH; k++) begin : g_csa
            logic [TW-1:0] nxt;
            par_csa_level #(
                .W    (W),
                .LO   (LO),
                .HI   (HI),
                .MAXT (MAXT),
                .IN_T (terms_at(N_OPS, k - 1))
            ) u_csa (
                .clk       (clk),
                .rst_n     (rst_n),
                .split     (split_t'(lvl[k-1][TW +: 2])),
                .in_terms  (lvl[k-1][TW-1:0]),
                .out_terms (nxt)
            );
            assign raw[k] = {lvl[k-1][TW +: 2], nxt};
        end
    endgenerate

    par_final_add #(
        .W    (W),
        .LO   (LO),
        .HI   (HI),
        .MAXT (MAXT)
    ) u_final (
        .clk   (clk),
        .rst_n (rst_n),
        .split (split_t'(lvl[DEPTH][TW +: 2])),
        .terms (lvl[DEPTH][TW-1:0]),
        .sum   (sum)
    );

endmodule

// File: tb/part_add_reduce_test.sv
// Scoreboard bench: a driver pushes expected sums with their issue cycle,
// a monitor pops and compares them when the pipeline should deliver.
module part_add_reduce_test;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 9;
    localparam int W   = 16;
    localparam logic [15:0] MASK = 16'h0015;
    localparam int LAT = 3;   // popcount of MASK

    typedef struct {
        logic [W-1:0] val;
        int           issue;
        logic         lo;
        logic         hi;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] ops = '0;
    logic           lo_en = 1'b0;
    logic           hi_en = 1'b0;
    logic [W-1:0]   sum;
    logic [W-1:0]   sum_empty;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    part_add_reduce #(.N_OPS(N), .W(W), .REG_MASK(MASK)) uut (
        .clk(clk), .rst_n(rst_n), .ops(ops),
        .split_lo_en(lo_en), .split_hi_en(hi_en), .sum(sum));

    part_add_reduce #(.N_OPS(0), .W(W), .REG_MASK(16'h0000)) uut_empty (
        .clk(clk), .rst_n(rst_n), .ops(ops[W-1:0]),
        .split_lo_en(lo_en), .split_hi_en(hi_en), .sum(sum_empty));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Lane-wise reference built from the requirements.
    function automatic logic [W-1:0] model(input logic [N*W-1:0] v,
                                           input logic lo, input logic hi);
        logic [15:0] full;
        logic [7:0]  b_hi, b_lo;
        logic [11:0] t_hi;
        logic [3:0]  n1, n0;
        full = 0; b_hi = 0; b_lo = 0; t_hi = 0; n1 = 0; n0 = 0;
        for (int i = 0; i < N; i++) begin
            full = full + v[i*W +: 16];
            b_hi = b_hi + v[i*W+8 +: 8];
            b_lo = b_lo + v[i*W +: 8];
            t_hi = t_hi + v[i*W+4 +: 12];
            n1   = n1 + v[i*W+4 +: 4];
            n0   = n0 + v[i*W +: 4];
        end
        if (!lo && !hi) return full;
        if (!lo && hi)  return {b_hi, b_lo};
        if (lo && !hi)  return {t_hi, n0};
        return {b_hi, n1, n0};
    endfunction

    function automatic string req_of(input logic lo, input logic hi);
        if (!lo && !hi) return "R2";
        if (!lo && hi)  return "R3";
        if (lo && !hi)  return "R4";
        return "R5";
    endfunction

    task automatic next_rand(output logic [31:0] r);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        r = rng;
    endtask

    task automatic check(input string tag, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [N*W-1:0] v, input logic lo, input logic hi);
        item_t it;
        @(negedge clk);
        ops = v; lo_en = lo; hi_en = hi;
        it.val = model(v, lo, hi); it.issue = cyc; it.lo = lo; it.hi = hi;
        q.push_back(it);
    endtask

    task automatic rand_ops(output logic [N*W-1:0] v);
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin
            next_rand(r);
            v[i*W +: W] = r[W-1:0];
        end
    endtask

    // Monitor: count edges and compare the item due in this cycle.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #(CLK_PERIOD/4);
            if (rst_n) check("R1 empty operand set", sum_empty, '0);
            if (q.size() > 0 && q[0].issue + LAT <= cyc) begin
                item_t it;
                it = q.pop_front();
                if (it.issue + LAT != cyc) begin
                    checks++; fails++;
                    $display("FAIL R6 missed slot: actual cycle %0d expected %0d",
                             cyc, it.issue + LAT);
                end else begin
                    check({req_of(it.lo, it.hi), " R6 R7 lane sum"}, sum, it.val);
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [N*W-1:0] v;
        logic [31:0] r;
        ops = {N{16'hA5C3}};
        repeat (3) @(negedge clk);
        #1;
        check("R8 sum in reset", sum, '0);
        check("R1 empty in reset", sum_empty, '0);
        @(negedge clk);
        rst_n = 1'b1;
        ops = '0;
        #1;
        check("R8 sum after release", sum, '0);

        for (int c = 0; c < 4; c++) begin
            logic lo, hi;
            lo = c[1]; hi = c[0];
            drive('0, lo, hi);
            drive({N{16'hFFFF}}, lo, hi);
            drive({N{16'h0111}}, lo, hi);
            for (int k = 0; k < 4; k++) begin
                rand_ops(v);
                drive(v, lo, hi);
            end
        end
        // R7: split setting changes on every cycle.
        for (int k = 0; k < 40; k++) begin
            rand_ops(v);
            next_rand(r);
            drive(v, r[3], r[9]);
        end
        // R6: single wide value between zeros.
        drive('0, 1'b0, 1'b0);
        drive({{(N-1){16'h0000}}, 16'h7FFF}, 1'b0, 1'b0);
        for (int k = 0; k < LAT + 2; k++) drive('0, 1'b1, 1'b1);

        for (int k = 0; k < 50 && q.size() > 0; k++) @(negedge clk);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R6 results outstanding: actual %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule